// File: doc/BRIEF.md
# Ethernet Frame Buffer with Length Queues

This block sits between a 32-bit register bus and a byte-wide MAC stream. It buffers frames in both directions. On the transmit side, software writes each 64-bit data word as two 32-bit halves. It then writes the frame's byte count, and that write commits the frame to a length queue. A serializer takes counts from that queue and streams the bytes to the MAC.

On the receive side, the MAC delivers bytes with a last-byte marker. The block packs them into 64-bit words and stores them ahead of a commit pointer. When a frame ends, its byte count goes into a receive length queue. A frame is discarded as a whole, and the store rolls back to the frame's start, in two cases: its words would overrun the data store, or the length queue is already full when the frame ends. Software sees only whole frames.

The transmit stream is valid/ready. While `tx_valid` is high and `tx_ready` is low, the byte and its last flag stay frozen, and the stream never drops a byte. The receive stream has no ready. Each beat with `rx_valid` high is taken, and overload is handled by discarding frames, not by stalling. Bus reads return data in the same cycle as `bus_rd`, and any pop takes effect at that clock edge. Register byte addresses: 0x00 TX data high half, 0x04 TX data low half, 0x08 TX length, 0x0C status, 0x10 TX vacancy, 0x14 RX length, 0x18 RX status, 0x1C RX data high half, 0x20 RX data low half.

Top module: `efb_frame_buffer`

## Requirements
- R1: A write to 0x00 holds the upper 32 bits of a TX word, and a write to 0x04 pushes {held upper, written lower}. A read of 0x1C returns bits 63:32 of the oldest RX word. A read of 0x20 returns bits 31:0 of that word and pops it.
- R2: A read of 0x10 returns the number of free 64-bit words in the TX data store, which is TX_DEPTH minus the words held. Words pushed and popped in the same cycle keep this count exact.
- R3: Status bit 0 is 1 while the TX length queue holds LEN_DEPTH entries. A write to 0x08 in that state is ignored and no frame is queued.
- R4: Writing N to 0x08 makes the stream emit exactly N bytes. Byte k comes from word k/8, lane k%8, with lane 0 in bits 63:56. `tx_last` marks byte N-1.
- R5: A frame whose length is not a multiple of 8 still uses up its whole final word. The padding bytes are never emitted, and the next frame starts at a fresh word.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values into the next cycle.
- R7: A read of 0x14 returns the byte count of the oldest received frame without popping it. A read of 0x18 returns the same count and pops it. In the received words, lane order follows R4 and unused trailing lanes read as zero.
- R8: Status bit 1 is 1 exactly while received frame counts remain. Writing 1 to it does not clear it while counts remain.
- R9: If a received frame would need more words than remain free in the RX data store, the whole frame is discarded, status bit 2 is set, and earlier frames stay intact.
- R10: If the RX length queue is full when a frame's last byte arrives, the frame is discarded, its words are rolled back, and status bit 3 is set.
- R11: A read of 0x14 or 0x18 with no counts queued, or of 0x1C or 0x20 with no words stored, returns zero and sets status bit 4. Writing 1 to bits 2 to 4 of 0x0C clears them.
- R12: After reset, status reads zero, the vacancy reads TX_DEPTH, and `tx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| tx_valid | output | 1 | TX byte available |
| tx_ready | input | 1 | MAC accepts TX byte |
| tx_data | output | 8 | TX byte |
| tx_last | output | 1 | Final byte of the TX frame |
| rx_valid | input | 1 | RX byte present |
| rx_data | input | 8 | RX byte |
| rx_last | input | 1 | Final byte of the RX frame |

## Verification
Two events can fall in the same clock edge: a bus write to the low-half address pushing a TX word, and the serializer popping the word it has just finished. The bench provokes this by writing the words of the next frame back to back while a 64-byte frame drains at full rate. It repeats the run with a one-cycle shift, so a push lands on a pop edge in one of the two runs. The outcome is judged by the scoreboard, which must see every byte in order with `tx_last` in the right place, and by the vacancy reading TX_DEPTH once all traffic has drained.

// File: rtl/efb_pkg.sv
package efb_pkg;
  typedef enum logic [5:0] {
    A_TXD_HI  = 6'h00,
    A_TXD_LO  = 6'h04,
    A_TX_LEN  = 6'h08,
    A_STATUS  = 6'h0C,
    A_TX_VAC  = 6'h10,
    A_RX_LEN  = 6'h14,
    A_RX_STAT = 6'h18,
    A_RXD_HI  = 6'h1C,
    A_RXD_LO  = 6'h20
  } efb_addr_e;

  localparam int ST_TXLF  = 0;
  localparam int ST_RXDN  = 1;
  localparam int ST_ABD   = 2;
  localparam int ST_ABL   = 3;
  localparam int ST_UNDR  = 4;
endpackage

// File: rtl/efb_sync_fifo.sv
module efb_sync_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign dout    = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  // R2
  fifo_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R3
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full);
endmodule

// File: rtl/efb_tx_stream.sv
module efb_tx_stream #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] len_head,
  input  logic             len_empty,
  output logic             len_pop,
  input  logic [63:0]      word_head,
  input  logic             word_empty,
  output logic             word_pop,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  output logic             tx_last
);
  logic             busy;
  logic [LEN_W-1:0] left;
  logic [2:0]       lane;
  logic             fire;

  assign len_pop  = !busy && !len_empty;
  assign tx_valid = busy && !word_empty;
  assign tx_data  = word_head[8*(7-lane) +: 8];
  assign tx_last  = tx_valid && (left == LEN_W'(1));
  assign fire     = tx_valid && tx_ready;
  assign word_pop = fire && ((lane == 3'd7) || (left == LEN_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      left <= '0;
      lane <= '0;
    end else if (len_pop) begin
      busy <= (len_head != '0);
      left <= len_head;
      lane <= '0;
    end else if (fire) begin
      left <= left - 1'b1;
      lane <= lane + 1'b1;
      if (left == LEN_W'(1)) busy <= 1'b0;
    end
  end

  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R4
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && tx_last) |=> !tx_valid);
endmodule

// File: rtl/efb_rx_store.sv
module efb_rx_store #(
  parameter int DEPTH = 8,
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_last,
  input  logic             len_full,
  output logic             len_push,
  output logic [LEN_W-1:0] len_val,
  input  logic             rd_pop,
  output logic [63:0]      head,
  output logic             empty,
  output logic             abort_data,
  output logic             abort_len
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [63:0]      mem [DEPTH];
  logic [PW-1:0]    wr_ptr, cmt_ptr, rd_ptr;
  logic [63:0]      acc, acc_nxt;
  logic [2:0]       lane;
  logic [LEN_W-1:0] nbytes;
  logic             dropping, take, word_done, spec_full, wr_en;

  always_comb begin
    take       = rx_valid && !dropping;
    word_done  = take && ((lane == 3'd7) || rx_last);
    spec_full  = ((wr_ptr - rd_ptr) == PW'(DEPTH));
    abort_data = word_done && spec_full;
    abort_len  = take && rx_last && !abort_data && len_full;
    wr_en      = word_done && !abort_data && !abort_len;
    len_push   = take && rx_last && !abort_data && !len_full;
    len_val    = nbytes + 1'b1;
    acc_nxt    = (lane == 3'd0) ? 64'd0 : acc;
    acc_nxt[8*(7-lane) +: 8] = rx_data;
    empty      = (rd_ptr == cmt_ptr);
    head       = mem[rd_ptr[AW-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      cmt_ptr  <= '0;
      rd_ptr   <= '0;
      acc      <= '0;
      lane     <= '0;
      nbytes   <= '0;
      dropping <= 1'b0;
    end else begin
      if (take) begin
        acc    <= acc_nxt;
        lane   <= rx_last ? 3'd0 : lane + 1'b1;
        nbytes <= rx_last ? '0 : nbytes + 1'b1;
      end
      if (abort_data) begin
        dropping <= !rx_last;
        lane     <= '0;
        nbytes   <= '0;
      end else if (rx_valid && dropping && rx_last) begin
        dropping <= 1'b0;
      end
      if (abort_data || abort_len) wr_ptr <= cmt_ptr;
      else if (wr_en)              wr_ptr <= wr_ptr + 1'b1;
      if (len_push) cmt_ptr <= wr_ptr + 1'b1;
      if (rd_pop && !empty) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr[AW-1:0]] <= acc_nxt;
  end

  // R9
  rollback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_data || abort_len) |=> (wr_ptr == cmt_ptr));

  // R7
  commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_push |=> !empty);
endmodule

// File: rtl/efb_frame_buffer.sv
module efb_frame_buffer
  import efb_pkg::*;
#(
  parameter int TX_DEPTH  = 16,
  parameter int RX_DEPTH  = 8,
  parameter int LEN_DEPTH = 2,
  parameter int LEN_W     = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_last
);
  localparam int TCW = $clog2(TX_DEPTH + 1);
  localparam int LCW = $clog2(LEN_DEPTH + 1);

  logic [31:0]      hi_hold;
  logic [63:0]      txw_head, rxd_head;
  logic             txw_full, txw_empty, txw_pop;
  logic [TCW-1:0]   txw_count;
  logic [LEN_W-1:0] txl_head, rxl_head, rxl_din;
  logic             txl_full, txl_empty, txl_pop;
  logic             rxl_full, rxl_empty, rxl_push;
  logic [LCW-1:0]   txl_count, rxl_count;
  logic             rxd_empty, abd_evt, abl_evt;
  logic             abd_q, abl_q, und_q, und_evt, st_wr;
  logic             rd_rxl, rd_rxd;

  assign rd_rxl  = bus_rd && (bus_addr == A_RX_LEN || bus_addr == A_RX_STAT);
  assign rd_rxd  = bus_rd && (bus_addr == A_RXD_HI || bus_addr == A_RXD_LO);
  assign und_evt = (rd_rxl && rxl_empty) || (rd_rxd && rxd_empty);
  assign st_wr   = bus_wr && (bus_addr == A_STATUS);

  efb_sync_fifo #(.W(64), .DEPTH(TX_DEPTH)) u_txw (
    .clk, .rst_n,
    .push (bus_wr && bus_addr == A_TXD_LO), .din({hi_hold, bus_wdata}),
    .pop  (txw_pop), .dout(txw_head),
    .full (txw_full), .empty(txw_empty), .count(txw_count));

  efb_sync_fifo #(.W(LEN_W), .DEPTH(LEN_DEPTH)) u_txl (
    .clk, .rst_n,
    .push (bus_wr && bus_addr == A_TX_LEN), .din(bus_wdata[LEN_W-1:0]),
    .pop  (txl_pop), .dout(txl_head),
    .full (txl_full), .empty(txl_empty), .count(txl_count));

  efb_sync_fifo #(.W(LEN_W), .DEPTH(LEN_DEPTH)) u_rxl (
    .clk, .rst_n,
    .push (rxl_push), .din(rxl_din),
    .pop  (bus_rd && bus_addr == A_RX_STAT), .dout(rxl_head),
    .full (rxl_full), .empty(rxl_empty), .count(rxl_count));

  efb_tx_stream #(.LEN_W(LEN_W)) u_txs (
    .clk, .rst_n,
    .len_head(txl_head), .len_empty(txl_empty), .len_pop(txl_pop),
    .word_head(txw_head), .word_empty(txw_empty), .word_pop(txw_pop),
    .tx_valid, .tx_ready, .tx_data, .tx_last);

  efb_rx_store #(.DEPTH(RX_DEPTH), .LEN_W(LEN_W)) u_rxs (
    .clk, .rst_n,
    .rx_valid, .rx_data, .rx_last,
    .len_full(rxl_full), .len_push(rxl_push), .len_val(rxl_din),
    .rd_pop(bus_rd && bus_addr == A_RXD_LO), .head(rxd_head), .empty(rxd_empty),
    .abort_data(abd_evt), .abort_len(abl_evt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_hold <= '0;
      abd_q   <= 1'b0;
      abl_q   <= 1'b0;
      und_q   <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_TXD_HI) hi_hold <= bus_wdata;
      if (abd_evt) abd_q <= 1'b1;
      else if (st_wr && bus_wdata[ST_ABD]) abd_q <= 1'b0;
      if (abl_evt) abl_q <= 1'b1;
      else if (st_wr && bus_wdata[ST_ABL]) abl_q <= 1'b0;
      if (und_evt) und_q <= 1'b1;
      else if (st_wr && bus_wdata[ST_UNDR]) und_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_STATUS: begin
          bus_rdata[ST_TXLF] = txl_full;
          bus_rdata[ST_RXDN] = !rxl_empty;
          bus_rdata[ST_ABD]  = abd_q;
          bus_rdata[ST_ABL]  = abl_q;
          bus_rdata[ST_UNDR] = und_q;
        end
        A_TX_VAC:            bus_rdata = 32'(TX_DEPTH) - 32'(txw_count);
        A_RX_LEN, A_RX_STAT: bus_rdata = rxl_empty ? '0 : 32'(rxl_head);
        A_RXD_HI:            bus_rdata = rxd_empty ? '0 : rxd_head[63:32];
        A_RXD_LO:            bus_rdata = rxd_empty ? '0 : rxd_head[31:0];
        default:             bus_rdata = '0;
      endcase
    end
  end

  // R11
  underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_RX_LEN && rxl_empty) |=> und_q);

  // R8
  done_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && bus_wdata[ST_RXDN] && !rxl_empty && !(bus_rd && bus_addr == A_RX_STAT))
      |=> !rxl_empty);

  // R3
  len_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txl_count <= LCW'(LEN_DEPTH)) && (rxl_count <= LCW'(LEN_DEPTH)));

  // R2
  vac_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txw_full |-> (txw_count == TCW'(TX_DEPTH)));
endmodule

// File: tb/tb_efb_frame_buffer.sv
module tb_efb_frame_buffer;
  import efb_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        tx_valid, tx_ready = 1'b0, tx_last;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0]  rx_data = '0;

  int checks = 0, errors = 0;
  int ready_mode = 0;
  int tick = 0;
  logic [8:0] exp_q[$];
  logic       prev_stall = 1'b0;
  logic [7:0] prev_data = '0;
  logic       prev_last = 1'b0;

  always #2 clk = ~clk;

  efb_frame_buffer dut (
    .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata,
    .tx_valid, .tx_ready, .tx_data, .tx_last, .rx_valid, .rx_data, .rx_last);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pbyte(input int seed, input int i, input int len);
    return (i < len) ? 8'((seed * 37) + (i * 5) + 1) : 8'hEE;
  endfunction

  function automatic logic [63:0] pword(input int seed, input int w, input int len, input logic [7:0] pad);
    logic [63:0] r;
    for (int k = 0; k < 8; k++)
      r[8*(7-k) +: 8] = ((8*w + k) < len) ? pbyte(seed, 8*w + k, len) : pad;
    return r;
  endfunction

  always begin
    @(posedge clk);
    #1;
    tick++;
    tx_ready = (ready_mode == 1) || ((ready_mode == 2) && (tick % 3 != 0));
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        chk("R6 held valid", 64'(tx_valid), 64'd1);
        chk("R6 held byte", {55'd0, tx_last, tx_data}, {55'd0, prev_last, prev_data});
      end
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0) begin
          chk("R4 unexpected byte", {55'd0, tx_last, tx_data}, 64'h1FF);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk("R4 R5 stream byte", {55'd0, tx_last, tx_data}, {55'd0, e});
        end
      end
      prev_stall = tx_valid && !tx_ready;
      prev_data  = tx_data;
      prev_last  = tx_last;
    end
  end

  task automatic bwr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    brd(a, v);
    chk(req, 64'(v), 64'(exp));
  endtask

  task automatic tx_words(input int len, input int seed);
    for (int w = 0; w < (len + 7) / 8; w++) begin
      logic [63:0] wd;
      wd = pword(seed, w, len, 8'hEE);
      bwr(A_TXD_HI, wd[63:32]);
      bwr(A_TXD_LO, wd[31:0]);
    end
  endtask

  task automatic tx_queue(input int len, input int seed);
    for (int i = 0; i < len; i++) exp_q.push_back({(i == len - 1), pbyte(seed, i, len)});
    bwr(A_TX_LEN, 32'(len));
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
  endtask

  task automatic send_rx(input int len, input int seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = pbyte(seed, i, len); rx_last = (i == len - 1);
      @(posedge clk);
      #1 rx_valid = 1'b0; rx_last = 1'b0;
    end
  endtask

  task automatic rd_frame(input int len, input int seed, input string req);
    rd_chk(A_RX_LEN, 32'(len), {req, " R7 length"});
    for (int w = 0; w < (len + 7) / 8; w++) begin
      logic [63:0] wd;
      wd = pword(seed, w, len, 8'h00);
      rd_chk(A_RXD_HI, wd[63:32], {req, " R1 R7 high half"});
      rd_chk(A_RXD_LO, wd[31:0], {req, " R1 R7 low half"});
    end
    rd_chk(A_RX_STAT, 32'(len), {req, " R7 status pop"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R12 reset state
    rd_chk(A_STATUS, 32'h0, "R12 status");
    rd_chk(A_TX_VAC, 32'd16, "R12 vacancy");
    @(negedge clk);
    chk("R12 tx_valid", 64'(tx_valid), 64'd0);

    // R1 R2 R4 R5 R6: stalled then toggling ready
    ready_mode = 0;
    tx_words(13, 1); tx_queue(13, 1);
    rd_chk(A_TX_VAC, 32'd14, "R2 vacancy after two words");
    tx_words(8, 2); tx_queue(8, 2);
    rd_chk(A_TX_VAC, 32'd13, "R2 vacancy after three words");
    ready_mode = 2;
    drain();
    rd_chk(A_TX_VAC, 32'd16, "R2 vacancy drained");

    // R3 length queue full
    ready_mode = 0;
    tx_words(8, 3); tx_queue(8, 3);
    tx_words(8, 4); tx_queue(8, 4);
    tx_words(8, 5); tx_queue(8, 5);
    repeat (2) @(posedge clk);
    rd_chk(A_STATUS, 32'h1, "R3 length full flag");
    bwr(A_TX_LEN, 32'd8);
    ready_mode = 1;
    drain();
    tx_words(5, 6); tx_queue(5, 6);
    drain();
    rd_chk(A_TX_VAC, 32'd16, "R3 ignored length left no frame");
    rd_chk(A_STATUS, 32'h0, "R3 flag clear");

    // R2 push and pop in the same cycle
    tx_words(64, 7); tx_queue(64, 7);
    tx_words(64, 8); tx_queue(64, 8);
    drain();
    tx_words(64, 9); tx_queue(64, 9);
    @(posedge clk);
    tx_words(64, 10); tx_queue(64, 10);
    drain();
    rd_chk(A_TX_VAC, 32'd16, "R2 vacancy after overlapped push and pop");

    // R7 R8 single frame
    send_rx(13, 20);
    rd_chk(A_STATUS, 32'h2, "R8 done set");
    rd_frame(13, 20, "f20");
    rd_chk(A_STATUS, 32'h0, "R8 done clear after last pop");

    // R8 write-one does not clear with entries left
    send_rx(5, 21);
    send_rx(9, 22);
    bwr(A_STATUS, 32'h2);
    rd_chk(A_STATUS, 32'h2, "R8 done survives write");
    rd_frame(5, 21, "f21");
    rd_chk(A_STATUS, 32'h2, "R8 done with one left");
    rd_frame(9, 22, "f22");
    rd_chk(A_STATUS, 32'h0, "R8 done clear");

    // R10 length queue full at frame end
    send_rx(8, 23);
    send_rx(8, 24);
    send_rx(16, 25);
    rd_chk(A_STATUS, 32'hA, "R10 length abort flag");
    rd_frame(8, 23, "f23");
    rd_frame(8, 24, "f24");
    rd_chk(A_RXD_LO, 32'h0, "R10 rolled back words absent");
    rd_chk(A_STATUS, 32'h18, "R11 underrun set");
    bwr(A_STATUS, 32'h1C);
    rd_chk(A_STATUS, 32'h0, "R11 flags cleared");

    // R9 data store overflow
    send_rx(40, 26);
    send_rx(30, 27);
    rd_chk(A_STATUS, 32'h6, "R9 data abort flag");
    rd_frame(40, 26, "f26 R9");
    rd_chk(A_RX_LEN, 32'h0, "R11 empty length read");
    rd_chk(A_STATUS, 32'h14, "R9 R11 flags");
    bwr(A_STATUS, 32'h1C);
    send_rx(11, 28);
    rd_frame(11, 28, "f28 R9 recovery");
    rd_chk(A_STATUS, 32'h0, "R11 final status");

    chk("R4 scoreboard empty", 64'(exp_q.size()), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule